// File: doc/BRIEF.md
# MSI Event Queue Controller

This block turns inbound message-signalled interrupt writes into entries of circular event queues kept in system memory. It serves several independent groups. Each group has its own 64-slot ring of 32-bit words, a control register, a head pointer that software owns, a tail pointer that hardware owns, and a level interrupt line. An inbound write carries an address and a data word. The offset of the address from a programmable target base selects the group. The data word is stored unchanged at the slot the group's tail points to, through a simple memory write port that returns a completion pulse.

Software programs two 64-bit page bases: one for the queue memory and one for the inbound target window. It sets per-group control bits, reads the tail pointers and moves the head pointers forward once it has consumed entries. A strap input chooses one of two layouts. In the packed layout all queues share one region and the group targets are adjacent words. In the split layout every queue and every target sits in its own 4 KB page.

Top module: `msiq_ctrl`

## Requirements
- R1: After reset every head, tail and control register reads 0, every irq bit is 0, err_flag is 0 and in_ready is 1.
- R2: Register words 0x00/0x01 hold the low/high halves of the queue page base and 0x02/0x03 the low/high halves of the target page base. Each reads back what was written.
- R3: In the packed layout (region_mode=0), a write to target base + 4·g goes to group g. Its data is written unmodified to queue base + 256·g + 4·tail.
- R4: In the split layout (region_mode=1), both strides are 4096 bytes, so group g's target is target base + 4096·g and its slot is queue base + 4096·g + 4·tail. An address valid only in the packed layout is dropped.
- R5: mem_wr_valid, mem_wr_addr and mem_wr_data hold until mem_wr_done. The tail advances by exactly one, modulo 64, in the cycle after the completion. Before the completion, a tail read still returns the old value.
- R6: Group g's registers sit at word 0x10+4·g (control), 0x11+4·g (head, read/write, low 6 bits kept) and 0x12+4·g (tail, read-only; writes are ignored).
- R7: When a group holds 63 pending entries (tail+1 equals head modulo 64), in_ready is 0 for writes to it. in_ready returns to 1 once a head write frees a slot.
- R8: irq[g] is 1 exactly when control bits 0, 1 and 11 are all set and head differs from tail. It falls in the first cycle after a head write makes them equal.
- R9: An accepted write that matches no group, or whose group has control bit 0 clear, produces no memory write, leaves every tail unchanged and sets err_flag. err_flag stays set until reset.
- R10: Control register reads return only bit 0 (queue enable), bit 1 (per-event interrupt enable) and bit 11 (interrupt enable); all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| region_mode | input | 1 | 0 = packed layout, 1 = one 4 KB page per group; static while out of reset |
| in_valid | input | 1 | Inbound write present |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| in_ready | output | 1 | Inbound write accepted when high with in_valid |
| mem_wr_valid | output | 1 | Queue memory write request |
| mem_wr_addr | output | 64 | Queue slot byte address |
| mem_wr_data | output | 32 | Entry word |
| mem_wr_done | input | 1 | One-cycle completion of the pending memory write |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq | output | 6 | Per-group level interrupt |
| err_flag | output | 1 | Sticky flag for dropped inbound writes |

## Verification
The bench fills one group to 63 pending entries and checks that a stall is seen at that point and not one slot earlier. A design that used the wrong full test would either overwrite unread entries or lose a slot. It then wraps the tail past 63, which catches pointer arithmetic that does not wrap modulo 64. It holds back the memory completion for several cycles and reads the tail in the meantime, so a design that moves the tail at acceptance, before the slot holds data, is exposed. It also sends writes to disabled groups and to misaligned addresses, and repeats in the split layout an address that is legal only in the packed one, so wrong decoding shows up as a memory write, a moved tail or a missing error flag.

// File: rtl/msiq_pkg.sv
package msiq_pkg;

    localparam int CTRL_QEN_BIT = 0;
    localparam int CTRL_EVT_BIT = 1;
    localparam int CTRL_IRQ_BIT = 11;

    typedef struct packed {
        logic irq_en;
        logic evt_en;
        logic q_en;
    } grp_ctrl_t;

    typedef enum logic [1:0] {
        FLD_CTRL = 2'd0,
        FLD_HEAD = 2'd1,
        FLD_TAIL = 2'd2,
        FLD_RSVD = 2'd3
    } grp_field_e;

    function automatic grp_ctrl_t ctrl_unpack(input logic [31:0] w);
        grp_ctrl_t c;
        c.q_en   = w[CTRL_QEN_BIT];
        c.evt_en = w[CTRL_EVT_BIT];
        c.irq_en = w[CTRL_IRQ_BIT];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input grp_ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CTRL_QEN_BIT] = c.q_en;
        w[CTRL_EVT_BIT] = c.evt_en;
        w[CTRL_IRQ_BIT] = c.irq_en;
        return w;
    endfunction

endpackage

// File: rtl/msiq_decode.sv
module msiq_decode #(
    parameter int N_GRP        = 6,
    parameter int AW           = 64,
    parameter int GW           = 3,
    parameter int REGION_SHIFT = 12
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] msi_base,
    input  logic          region_mode,
    output logic          hit,
    output logic [GW-1:0] grp
);
    logic [AW-1:0]    offset;
    logic [N_GRP-1:0] match;

    assign offset = addr - msi_base;

    for (genvar g = 0; g < N_GRP; g++) begin : g_match
        assign match[g] = (offset == (region_mode ? (AW'(g) << REGION_SHIFT)
                                                  : (AW'(g) << 2)));
    end

    always_comb begin
        hit = |match;
        grp = '0;
        for (int g = 0; g < N_GRP; g++) begin
            if (match[g]) grp = GW'(g);
        end
    end
endmodule

// File: rtl/msiq_group.sv
module msiq_group
    import msiq_pkg::*;
#(
    parameter int PTR_W = 6,
    parameter int RDW   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we_i,
    input  logic             head_we_i,
    input  logic [RDW-1:0]   wdata_i,
    input  logic             push_i,
    output grp_ctrl_t        ctrl_o,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] tail_o,
    output logic             full_o,
    output logic             irq_o
);
    grp_ctrl_t        ctrl_q;
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (ctrl_we_i) ctrl_q <= ctrl_unpack(wdata_i);
            if (head_we_i) head_q <= wdata_i[PTR_W-1:0];
            if (push_i)    tail_q <= tail_q + PTR_W'(1);
        end
    end

    assign ctrl_o = ctrl_q;
    assign head_o = head_q;
    assign tail_o = tail_q;
    assign full_o = ((tail_q + PTR_W'(1)) == head_q);
    assign irq_o  = ctrl_q.q_en & ctrl_q.evt_en & ctrl_q.irq_en & (head_q != tail_q);

    // R5: tail only moves on a completed memory write, one slot at a time
    assert_tail_step_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(tail_q) |-> ($past(push_i) && tail_q == $past(tail_q) + PTR_W'(1)));

    // R6: head is moved only by software
    assert_head_sw_only_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(head_q) |-> $past(head_we_i));

    // R7: no entry is committed into a full ring
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o);

    // R8: catching up the head drops the interrupt next cycle
    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (head_we_i && wdata_i[PTR_W-1:0] == tail_q && !push_i) |=> !irq_o);
endmodule

// File: rtl/msiq_writer.sv
module msiq_writer #(
    parameter int AW           = 64,
    parameter int DW           = 32,
    parameter int GW           = 3,
    parameter int PTR_W        = 6,
    parameter int REGION_SHIFT = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [GW-1:0]    start_grp_i,
    input  logic [PTR_W-1:0] start_tail_i,
    input  logic [DW-1:0]    start_data_i,
    input  logic [AW-1:0]    q_base_i,
    input  logic             region_mode_i,
    output logic             busy_o,
    output logic             mem_wr_valid,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [DW-1:0]    mem_wr_data,
    input  logic             mem_wr_done,
    output logic             push_o,
    output logic [GW-1:0]    push_grp_o
);
    localparam int SLOT_SHIFT = 2;
    localparam int RING_SHIFT = PTR_W + SLOT_SHIFT;

    logic          busy_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [GW-1:0] grp_q;
    logic [AW-1:0] ring_off;
    logic [AW-1:0] slot_addr;

    assign ring_off  = region_mode_i ? (AW'(start_grp_i) << REGION_SHIFT)
                                     : (AW'(start_grp_i) << RING_SHIFT);
    assign slot_addr = q_base_i + ring_off + (AW'(start_tail_i) << SLOT_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            grp_q  <= '0;
        end else if (!busy_q && start_i) begin
            busy_q <= 1'b1;
            addr_q <= slot_addr;
            data_q <= start_data_i;
            grp_q  <= start_grp_i;
        end else if (busy_q && mem_wr_done) begin
            busy_q <= 1'b0;
        end
    end

    assign busy_o       = busy_q;
    assign mem_wr_valid = busy_q;
    assign mem_wr_addr  = addr_q;
    assign mem_wr_data  = data_q;
    assign push_o       = busy_q && mem_wr_done;
    assign push_grp_o   = grp_q;

    // R5: request held steady until completion
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_done) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
endmodule

// File: rtl/msiq_ctrl.sv
module msiq_ctrl
    import msiq_pkg::*;
#(
    parameter int N_GRP        = 6,
    parameter int PTR_W        = 6,
    parameter int AW           = 64,
    parameter int DW           = 32,
    parameter int RAW          = 8,
    parameter int RDW          = 32,
    parameter int REGION_SHIFT = 12,
    parameter int GRP_REG_BASE = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             region_mode,
    input  logic             in_valid,
    input  logic [AW-1:0]    in_addr,
    input  logic [DW-1:0]    in_data,
    output logic             in_ready,
    output logic             mem_wr_valid,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [DW-1:0]    mem_wr_data,
    input  logic             mem_wr_done,
    input  logic             reg_wr,
    input  logic [RAW-1:0]   reg_addr,
    input  logic [RDW-1:0]   reg_wdata,
    output logic [RDW-1:0]   reg_rdata,
    output logic [N_GRP-1:0] irq,
    output logic             err_flag
);
    localparam int GW     = (N_GRP > 1) ? $clog2(N_GRP) : 1;
    localparam int HALF_W = AW / 2;

    logic [AW-1:0]    q_base_q;
    logic [AW-1:0]    t_base_q;
    logic             err_q;

    grp_ctrl_t        ctrl_v [N_GRP];
    logic [PTR_W-1:0] head_v [N_GRP];
    logic [PTR_W-1:0] tail_v [N_GRP];
    logic [N_GRP-1:0] full_v;
    logic [N_GRP-1:0] push_v;

    logic             dec_hit;
    logic [GW-1:0]    dec_grp;
    logic             dec_ok;
    logic             wr_busy;
    logic             wr_push;
    logic [GW-1:0]    wr_push_grp;
    logic             accept;

    msiq_decode #(
        .N_GRP(N_GRP), .AW(AW), .GW(GW), .REGION_SHIFT(REGION_SHIFT)
    ) u_decode (
        .addr(in_addr), .msi_base(t_base_q), .region_mode(region_mode),
        .hit(dec_hit), .grp(dec_grp)
    );

    assign dec_ok   = dec_hit && ctrl_v[dec_grp].q_en;
    assign in_ready = !wr_busy && !(dec_ok && full_v[dec_grp]);
    assign accept   = in_valid && in_ready;

    msiq_writer #(
        .AW(AW), .DW(DW), .GW(GW), .PTR_W(PTR_W), .REGION_SHIFT(REGION_SHIFT)
    ) u_writer (
        .clk(clk), .rst(rst),
        .start_i(accept && dec_ok), .start_grp_i(dec_grp),
        .start_tail_i(tail_v[dec_grp]), .start_data_i(in_data),
        .q_base_i(q_base_q), .region_mode_i(region_mode),
        .busy_o(wr_busy),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_done(mem_wr_done),
        .push_o(wr_push), .push_grp_o(wr_push_grp)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam int REG_G = GRP_REG_BASE + 4 * g;
        logic ctrl_we;
        logic head_we;
        assign ctrl_we   = reg_wr && (reg_addr == RAW'(REG_G + int'(FLD_CTRL)));
        assign head_we   = reg_wr && (reg_addr == RAW'(REG_G + int'(FLD_HEAD)));
        assign push_v[g] = wr_push && (wr_push_grp == GW'(g));

        msiq_group #(.PTR_W(PTR_W), .RDW(RDW)) u_grp (
            .clk(clk), .rst(rst),
            .ctrl_we_i(ctrl_we), .head_we_i(head_we), .wdata_i(reg_wdata),
            .push_i(push_v[g]),
            .ctrl_o(ctrl_v[g]), .head_o(head_v[g]), .tail_o(tail_v[g]),
            .full_o(full_v[g]), .irq_o(irq[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_base_q <= '0;
            t_base_q <= '0;
            err_q    <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    RAW'(0): q_base_q[HALF_W-1:0]  <= reg_wdata[HALF_W-1:0];
                    RAW'(1): q_base_q[AW-1:HALF_W] <= reg_wdata[HALF_W-1:0];
                    RAW'(2): t_base_q[HALF_W-1:0]  <= reg_wdata[HALF_W-1:0];
                    RAW'(3): t_base_q[AW-1:HALF_W] <= reg_wdata[HALF_W-1:0];
                    default: ;
                endcase
            end
            if (accept && !dec_ok) err_q <= 1'b1;
        end
    end

    assign err_flag = err_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RAW'(0): reg_rdata = RDW'(q_base_q[HALF_W-1:0]);
            RAW'(1): reg_rdata = RDW'(q_base_q[AW-1:HALF_W]);
            RAW'(2): reg_rdata = RDW'(t_base_q[HALF_W-1:0]);
            RAW'(3): reg_rdata = RDW'(t_base_q[AW-1:HALF_W]);
            default: ;
        endcase
        for (int g = 0; g < N_GRP; g++) begin
            if (reg_addr == RAW'(GRP_REG_BASE + 4 * g + int'(FLD_CTRL)))
                reg_rdata = ctrl_pack(ctrl_v[g]);
            if (reg_addr == RAW'(GRP_REG_BASE + 4 * g + int'(FLD_HEAD)))
                reg_rdata = RDW'(head_v[g]);
            if (reg_addr == RAW'(GRP_REG_BASE + 4 * g + int'(FLD_TAIL)))
                reg_rdata = RDW'(tail_v[g]);
        end
    end

    // R9: error flag is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R9: a dropped write never reaches memory
    assert_drop_no_write_R9: assert property (@(posedge clk) disable iff (rst)
        (accept && !dec_ok) |=> !mem_wr_valid);

    // R5: no new request is accepted while one is outstanding
    assert_single_flight_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_done) |-> !in_ready);

    // R3: at most one group is ever pushed
    assert_push_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(push_v));
endmodule

// File: tb/tb_msiq_ctrl.sv
module tb_msiq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          region_mode = 1'b0;
    logic          in_valid = 1'b0;
    logic [63:0]   in_addr = '0;
    logic [31:0]   in_data = '0;
    logic          in_ready;
    logic          mem_wr_valid;
    logic [63:0]   mem_wr_addr;
    logic [31:0]   mem_wr_data;
    logic          mem_wr_done = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NG-1:0] irq;
    logic          err_flag;

    msiq_ctrl dut (
        .clk(clk), .rst(rst), .region_mode(region_mode),
        .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data), .in_ready(in_ready),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_done(mem_wr_done),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .err_flag(err_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [63:0] qbase = 64'h0000_0012_3400_0000;
    logic [63:0] tbase = 64'h0000_00AB_CDE0_0000;
    logic [5:0]  m_tail [NG];
    logic [5:0]  m_head [NG];

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<=150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_slot(input int g, input logic [5:0] t);
        return qbase + (region_mode ? 64'(g) * 64'd4096 : 64'(g) * 64'd256) + 64'(t) * 64'd4;
    endfunction

    function automatic logic [63:0] exp_target(input int g);
        return tbase + (region_mode ? 64'(g) * 64'd4096 : 64'(g) * 64'd4);
    endfunction

    function automatic logic [7:0] ra(input int g, input int f);
        return 8'(16 + 4 * g + f);
    endfunction

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic program_bases();
        reg_write(8'd0, qbase[31:0]);
        reg_write(8'd1, qbase[63:32]);
        reg_write(8'd2, tbase[31:0]);
        reg_write(8'd3, tbase[63:32]);
    endtask

    // send one write; ok=1 expects a queue commit to group g
    task automatic send(input logic [63:0] a, input logic [31:0] d, input int g,
                        input bit ok, input int lat);
        logic [63:0] slot;
        string tag;
        tag = region_mode ? "R4 slot" : "R3 slot";
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_data = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        if (!ok) begin
            chk("R9 no memory write", 64'(mem_wr_valid), 64'd0);
            chk("R9 err set", 64'(err_flag), 64'd1);
            return;
        end
        slot = exp_slot(g, m_tail[g]);
        chk("R5 request raised", 64'(mem_wr_valid), 64'd1);
        chk(tag, mem_wr_addr, slot);
        chk("R3 data unmodified", 64'(mem_wr_data), 64'(d));
        reg_addr = ra(g, 2);
        for (int i = 0; i < lat; i++) begin
            #1;
            chk("R5 tail held before completion", 64'(reg_rdata), 64'(m_tail[g]));
            @(negedge clk);
            #1;
            chk("R5 address held", mem_wr_addr, slot);
        end
        mem_wr_done = 1'b1;
        @(negedge clk);
        mem_wr_done = 1'b0;
        m_tail[g] = m_tail[g] + 6'd1;
        #1;
        chk("R5 tail advanced", 64'(reg_rdata), 64'(m_tail[g]));
    endtask

    task automatic consume(input int g);
        reg_write(ra(g, 1), 32'(m_tail[g]));
        m_head[g] = m_tail[g];
        chk("R8 irq drops after head catch-up", 64'(irq[g]), 64'd0);
    endtask

    task automatic do_reset(input logic mode);
        rst = 1'b1;
        region_mode = mode;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int g = 0; g < NG; g++) begin
            m_tail[g] = '0;
            m_head[g] = '0;
        end
        #1;
    endtask

    initial begin
        logic [31:0] rd;
        int seed_init;
        seed_init = $urandom(32'd20240611);

        do_reset(1'b0);

        // R1 reset state
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 err", 64'(err_flag), 64'd0);
        chk("R1 ready", 64'(in_ready), 64'd1);
        for (int g = 0; g < NG; g++) begin
            reg_read(ra(g, 0), rd); chk("R1 ctrl", 64'(rd), 64'd0);
            reg_read(ra(g, 1), rd); chk("R1 head", 64'(rd), 64'd0);
            reg_read(ra(g, 2), rd); chk("R1 tail", 64'(rd), 64'd0);
        end

        // R2 base registers
        program_bases();
        reg_read(8'd0, rd); chk("R2 qbase lo", 64'(rd), 64'(qbase[31:0]));
        reg_read(8'd1, rd); chk("R2 qbase hi", 64'(rd), 64'(qbase[63:32]));
        reg_read(8'd2, rd); chk("R2 tbase lo", 64'(rd), 64'(tbase[31:0]));
        reg_read(8'd3, rd); chk("R2 tbase hi", 64'(rd), 64'(tbase[63:32]));

        // R10 control readback
        reg_write(ra(5, 0), 32'hFFFF_FFFF);
        reg_read(ra(5, 0), rd); chk("R10 ctrl bits", 64'(rd), 64'h803);

        // R9 disabled group: group 0 still off
        send(exp_target(0), 32'h0000_0020, 0, 1'b0, 0);
        reg_read(ra(0, 2), rd); chk("R9 tail unchanged", 64'(rd), 64'd0);

        for (int g = 0; g < NG; g++) reg_write(ra(g, 0), 32'h803);

        // R3 directed sends with held-back completion
        send(exp_target(1), 32'h0000_0043, 1, 1'b1, 3);
        chk("R8 irq while pending", 64'(irq[1]), 64'd1);
        consume(1);
        send(exp_target(4), 32'hDEAD_BEEF, 4, 1'b1, 0);
        consume(4);

        // R9 misaligned address
        send(tbase + 64'd2, 32'h1, 0, 1'b0, 0);
        chk("R9 err stays set", 64'(err_flag), 64'd1);

        // R6 tail is read-only, head keeps 6 bits
        reg_write(ra(1, 2), 32'h0000_0015);
        reg_read(ra(1, 2), rd); chk("R6 tail write ignored", 64'(rd), 64'(m_tail[1]));
        reg_write(ra(0, 1), 32'hFFFF_FFC5);
        reg_read(ra(0, 1), rd); chk("R6 head masked", 64'(rd), 64'd5);
        chk("R8 irq with head!=tail", 64'(irq[0]), 64'd1);
        consume(0);

        // R8 interrupt gated by control bits
        reg_write(ra(3, 0), 32'h001);
        send(exp_target(3), 32'h60, 3, 1'b1, 1);
        chk("R8 irq gated off", 64'(irq[3]), 64'd0);
        reg_write(ra(3, 0), 32'h803);
        chk("R8 irq on enable", 64'(irq[3]), 64'd1);
        consume(3);

        // R7 fill group 2 to 63 pending, then wrap
        for (int i = 0; i < 63; i++) send(exp_target(2), 32'(i << 5), 2, 1'b1, 0);
        reg_read(ra(2, 2), rd); chk("R7 tail at 63 pending", 64'(rd), 64'(m_head[2] + 6'd63));
        @(negedge clk);
        in_valid = 1'b1; in_addr = exp_target(2); in_data = 32'h7;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R7 stalled when full", 64'(in_ready), 64'd0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        reg_write(ra(2, 1), 32'(m_head[2] + 6'd1));
        m_head[2] = m_head[2] + 6'd1;
        in_addr = exp_target(2);
        #1;
        chk("R7 ready after head moves", 64'(in_ready), 64'd1);
        send(exp_target(2), 32'h0000_0007, 2, 1'b1, 2);
        reg_read(ra(2, 2), rd); chk("R5 tail wrapped", 64'(rd), 64'd0);
        consume(2);

        // random traffic in packed layout
        for (int i = 0; i < 80; i++) begin
            int g;
            g = $urandom % NG;
            send(exp_target(g), $urandom, g, 1'b1, $urandom % 3);
            chk("R8 irq pending", 64'(irq[g]), 64'd1);
            if (($urandom % 4) == 0) consume(g);
        end
        for (int g = 0; g < NG; g++) consume(g);

        // R4 split layout
        do_reset(1'b1);
        program_bases();
        reg_write(ra(0, 0), 32'h803);
        reg_write(ra(4, 0), 32'h803);
        send(exp_target(4), 32'h0000_0081, 4, 1'b1, 1);
        send(exp_target(0), 32'h0000_0005, 0, 1'b1, 0);
        send(exp_target(4), 32'h0000_00A0, 4, 1'b1, 2);
        chk("R4 err clear before drop", 64'(err_flag), 64'd0);
        send(tbase + 64'd16, 32'h1, 4, 1'b0, 0);
        reg_read(ra(4, 2), rd); chk("R4 tail after drop", 64'(rd), 64'd2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule